// File: doc/BRIEF.md
# Counting barrier synchronizer

This block holds a group of N processors at a common meeting point until every one of them has reached it. Each processor raises its request line when it gets to the barrier. The block takes these arrivals one per cycle into a shared counter. An intake gate controls arrivals and a release gate controls departures, and exactly one of the two is open at any time.

When the counter reaches N, intake closes and the release gate opens. Processors then leave one per cycle, and each one's acknowledge rises as it leaves. The counter runs down by one for each departure. Intake opens again only when the counter is back at zero. A processor that leaves early and returns at once therefore waits until the whole group has left before it is counted again.

Each processor uses a four-phase handshake. It raises its request and waits for its acknowledge. It then drops its request, and the acknowledge falls one cycle later. Only after that is it eligible for the next barrier.

Top module: `barrier_sync`

## Requirements
- R1: After reset the arrival count is 0, the intake gate is open, the release gate is closed and every acknowledge is low.
- R2: While intake is open, at most one arrival is taken per cycle. The arrival taken is the lowest-indexed processor that has its request high and is neither counted already nor holding its acknowledge. Each arrival raises the count by exactly one.
- R3: No acknowledge rises while fewer than N processors have been counted, however long the requests are held.
- R4: On the clock edge that takes the Nth arrival, intake closes and the release gate opens. From the following edge on, one counted processor departs per cycle, in ascending index order. Its acknowledge bit goes high on the edge of its departure.
- R5: Each departure lowers the count by one. The departure that brings the count to 0 closes the release gate and reopens intake.
- R6: An acknowledge stays high while its request stays high. It returns low on the first edge at which its request is sampled low. A processor whose acknowledge is high is not taken as an arrival.
- R7: A request raised while the release gate is open is not counted. It is taken only after the count has returned to 0.
- R8: The count never exceeds N, and exactly one of the two gates is open in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Per-processor barrier request, held until acknowledged |
| ack | output | N | Per-processor release acknowledge, held until its request drops |

## Verification
The bench builds the block with N = 4. With this size a full fill-and-drain takes eight cycles. Every step of arrival priority and departure order can therefore be checked edge by edge. It also leaves room to interleave a processor that drops its request and re-raises it during the release phase, which exercises the re-entry lockout. A reset applied with three processors counted shows that the count is cleared: three later arrivals must not release the barrier.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

    // The two gates; exactly one is open at any time.
    typedef struct packed {
        logic intake_open;
        logic release_open;
    } gates_t;

    localparam gates_t GATES_RESET = '{intake_open: 1'b1, release_open: 1'b0};

endpackage

// File: rtl/barrier_pick.sv
// Fixed-priority one-hot picker: the lowest set index wins.
module barrier_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] cand,
    output logic [N-1:0] grant,
    output logic         any
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            if (i == 0) begin : g_first
                assign grant[i] = cand[i];
            end else begin : g_rest
                assign grant[i] = cand[i] & ~(|cand[i-1:0]);
            end
        end
    endgenerate

    assign any = |cand;
endmodule

// File: rtl/barrier_gate_ctl.sv
// Arrival counter with its intake and release gates.
module barrier_gate_ctl
    import barrier_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_arrival,
    input  logic          take_departure,
    output logic [CW-1:0] cnt,
    output gates_t        gates
);
    localparam logic [CW-1:0] FULL = CW'(N);
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        gates_t        g;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_arrival && st_q.g.intake_open) begin
            st_d.cnt = st_q.cnt + ONE;
            if (st_q.cnt + ONE == FULL) begin
                st_d.g.intake_open  = 1'b0;
                st_d.g.release_open = 1'b1;
            end
        end else if (take_departure && st_q.g.release_open) begin
            st_d.cnt = st_q.cnt - ONE;
            if (st_q.cnt == ONE) begin
                st_d.g.release_open = 1'b0;
                st_d.g.intake_open  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.g   <= GATES_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt   = st_q.cnt;
    assign gates = st_q.g;
endmodule

// File: rtl/barrier_sync.sv
// Counting barrier for N processors with req/ack handshakes.
module barrier_sync
    import barrier_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] ack
);
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        logic [N-1:0] counted;
        logic [N-1:0] ack;
    } proc_t;

    proc_t         pr_d, pr_q;
    logic [CW-1:0] cnt;
    gates_t        gates;
    logic          intake_open;
    logic          release_open;
    logic [N-1:0]  arr_cand, arr_grant;
    logic [N-1:0]  dep_cand, dep_grant;
    logic          arr_any, dep_any;

    assign intake_open  = gates.intake_open;
    assign release_open = gates.release_open;

    assign arr_cand = intake_open  ? (req & ~pr_q.counted & ~pr_q.ack) : '0;
    assign dep_cand = release_open ? pr_q.counted : '0;

    barrier_pick #(.N(N)) u_arr_pick (
        .cand (arr_cand),
        .grant(arr_grant),
        .any  (arr_any)
    );

    barrier_pick #(.N(N)) u_dep_pick (
        .cand (dep_cand),
        .grant(dep_grant),
        .any  (dep_any)
    );

    barrier_gate_ctl #(.N(N), .CW(CW)) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .take_arrival  (arr_any),
        .take_departure(dep_any),
        .cnt           (cnt),
        .gates         (gates)
    );

    always_comb begin
        pr_d         = pr_q;
        pr_d.counted = (pr_q.counted | arr_grant) & ~dep_grant;
        pr_d.ack     = dep_grant | (pr_q.ack & req);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_q <= '0;
        end else begin
            pr_q <= pr_d;
        end
    end

    assign ack = pr_q.ack;
endmodule

// File: rtl/barrier_sync_chk.sv
module barrier_sync_chk #(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  req,
    input logic [N-1:0]  ack,
    input logic [CW-1:0] count,
    input logic          intake_open,
    input logic          release_open
);
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(N));

    a_r8_one_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({intake_open, release_open}));

    a_r5_drain_step: assert property (@(posedge clk) disable iff (!rst_n)
        release_open |=> (count == $past(count) - CW'(1)));

    a_r5_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        (release_open && count == CW'(1)) |=> (intake_open && count == '0));

    a_r4_single_release: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ack & ~$past(ack)) <= 1);

    a_r2_single_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        intake_open |=> (count <= $past(count) + CW'(1)));

    generate
        for (genvar i = 0; i < N; i++) begin : g_lane
            a_r6_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (ack[i] && req[i]) |=> ack[i]);
            a_r6_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
                (ack[i] && !req[i]) |=> !ack[i]);
            a_r3_release_only: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ack[i]) |-> $past(release_open));
        end
    endgenerate
endmodule

bind barrier_sync barrier_sync_chk #(.N(N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .ack         (ack),
    .count       (cnt),
    .intake_open (intake_open),
    .release_open(release_open)
);

// File: tb/barrier_sync_bench.sv
module barrier_sync_bench;
    localparam int N = 4;
    localparam int NV = 37;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] ack;
    int           n_run = 0;
    int           n_fail = 0;
    int           cycles = 0;

    always #5 clk = ~clk;

    barrier_sync #(.N(N)) u_barrier_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req),
        .ack  (ack)
    );

    // Each entry: {req driven before the edge, ack expected after it}.
    localparam logic [7:0] VEC [NV] = '{
        // R2 R4: all four arrive together, fill then drain in index order
        {4'b1111, 4'b0000}, {4'b1111, 4'b0000}, {4'b1111, 4'b0000}, {4'b1111, 4'b0000},
        {4'b1111, 4'b0001}, {4'b1111, 4'b0011}, {4'b1111, 4'b0111}, {4'b1111, 4'b1111},
        // R6: P0 drops and re-arrives while the others still hold ack
        {4'b1110, 4'b1110}, {4'b1111, 4'b1110}, {4'b0001, 4'b0000},
        // R2: staggered arrivals P1, P3, P2, then drain
        {4'b0011, 4'b0000}, {4'b1011, 4'b0000}, {4'b1111, 4'b0000},
        {4'b1111, 4'b0001}, {4'b1111, 4'b0011}, {4'b1111, 4'b0111}, {4'b1111, 4'b1111},
        {4'b0000, 4'b0000},
        // R7: P0 leaves first and re-requests during the drain
        {4'b1111, 4'b0000}, {4'b1111, 4'b0000}, {4'b1111, 4'b0000}, {4'b1111, 4'b0000},
        {4'b1111, 4'b0001}, {4'b1110, 4'b0010}, {4'b1111, 4'b0110}, {4'b1111, 4'b1110},
        {4'b1111, 4'b1110}, {4'b0001, 4'b0000},
        // R5: P0 already counted, three more fill the barrier again
        {4'b1111, 4'b0000}, {4'b1111, 4'b0000}, {4'b1111, 4'b0000},
        {4'b1111, 4'b0001}, {4'b1111, 4'b0011}, {4'b1111, 4'b0111}, {4'b1111, 4'b1111},
        {4'b0000, 4'b0000}
    };

    task automatic check(input string tag, input logic [N-1:0] exp);
        n_run++;
        if (ack !== exp) begin
            n_fail++;
            $display("FAIL %s: ack=%b expected %b", tag, ack, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] r);
        @(negedge clk);
        req = r;
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, 5000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 during reset", '0);
        @(negedge clk);
        rst_n = 1'b1;
        step('0);
        check("R1 after reset", '0);

        for (int k = 0; k < NV; k++) begin
            step(VEC[k][7:4]);
            check($sformatf("table step %0d (R2 R4 R5 R6 R7)", k), VEC[k][3:0]);
        end

        // R3: three arrivals only, no release however long they wait
        for (int k = 0; k < 10; k++) begin
            step(4'b0111);
            check("R3 partial arrival holds", '0);
        end

        // R1: reset mid-barrier clears the count
        @(negedge clk);
        rst_n = 1'b0;
        step(4'b0111);
        check("R1 reset mid-barrier", '0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            step(4'b0111);
            check("R1 R3 count cleared by reset", '0);
        end

        // R4: last arrival then ordered release
        step(4'b1111);
        check("R4 last arrival", 4'b0000);
        step(4'b1111);
        check("R4 release P0", 4'b0001);
        step(4'b1111);
        check("R4 release P1", 4'b0011);
        step(4'b1111);
        check("R4 release P2", 4'b0111);
        step(4'b1111);
        check("R5 release P3", 4'b1111);
        step(4'b0000);
        check("R6 acks drop", 4'b0000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule